// File: doc/BRIEF.md
# Full-Duplex Serial Channel with Frame Handshake

This block is an asynchronous serial channel whose transmitter and receiver run at the same time, each with its own buffer register. Bytes to send enter through a valid/ready stream. Received bytes leave through a second valid/ready stream that is backed by two stages: a shift stage that assembles the incoming frame and a holding stage that presents the finished byte to the host. The next frame can arrive while the host still holds the previous one. Bit timing comes from an external `baud_tick` strobe that pulses sixteen times per bit.

The receiver accepts a start bit only when a 2-of-3 vote of its mid-bit samples is low, so short noise pulses are rejected. Every data, parity and stop bit is decided by the same vote. The transmitter and the receiver each raise a one-cycle interrupt pulse. Overrun, parity and framing errors set sticky flags that one status-read strobe clears. When flow control is on, `rts` tells the far end to pause until the host has taken the current frame, and a low `cts` holds back the next outgoing frame. A 2-bit select code steers the channel onto one of two receive pins and one of two transmit pins, so two links can share the channel in turn.

Stream rules: the transmit stream accepts a byte in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high exactly while the transmit buffer is empty. The receive stream offers a byte while `rx_valid` is high. It holds `rx_data` unchanged until a cycle with `rx_ready` high, and that cycle consumes the byte. A frame that completes while the holding stage is full and is not consumed in that cycle is lost. Back-pressure on the receive side therefore has a limit of one frame time.

Top module: `duplex_uart`

## Requirements
- R1: The selected transmit pin idles high. A frame on it is a low start bit, 8 data bits with the LSB first, an optional parity bit, then a high stop bit, and each bit lasts 16 `baud_tick` pulses. With parity on, the parity bit makes the count of ones in data plus parity even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1.
- R2: `tx_ready` is high only while the transmit buffer is empty. A byte can be written while the previous frame is still shifting out. `tx_irq` pulses for one cycle each time the buffer hands a byte to the shifter and becomes empty.
- R3: The receiver samples the selected pin at ticks 7, 8 and 9 of each bit, counted from the tick on which a low level is first seen, which is tick 0. It starts a frame only if at least two of the three start-bit samples are low. Otherwise it returns to idle and stores nothing.
- R4: Each received data bit is the majority of its three samples. A completed frame is placed in the holding stage, which raises `rx_valid`, and `rx_irq` pulses for one cycle.
- R5: `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low. A new frame can be shifted in while the holding stage is full, and it is stored if the host reads the held byte before the new frame completes.
- R6: If a frame completes while the holding stage has an unread byte, `err_overrun` is set, the new frame is discarded and the held byte is kept.
- R7: With parity on, a received parity bit that does not match the rule of R1 sets `err_parity`. The byte is still stored.
- R8: A stop bit whose majority is low sets `err_frame`.
- R9: The three error flags stay set across later good frames. A `stat_rd` pulse clears all three together. A new error in the same cycle wins over the clear.
- R10: With `cfg_hs_en`=1, `rts` is low while the holding stage has an unread byte and high otherwise. With `cfg_hs_en`=0, `rts` stays high.
- R11: With `cfg_hs_en`=1 and `cts` low, no new frame starts and the byte stays in the buffer, so `tx_ready` stays low. Transmission begins after `cts` goes high.
- R12: `cfg_pin_sel[0]` picks the receive pin (0 = `rxd_a`, 1 = `rxd_b`), and activity on the other receive pin is ignored. `cfg_pin_sel[1]` picks the transmit pin (0 = `txd_a`, 1 = `txd_b`), and the unselected transmit pin stays high.
- R13: Transmission and reception run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | Strobe, 16 pulses per bit time |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_hs_en | input | 1 | Enable RTS/CTS flow control |
| cfg_pin_sel | input | 2 | Bit 0 receive pin, bit 1 transmit pin |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Host takes the held byte |
| rx_data | output | 8 | Received byte |
| stat_rd | input | 1 | Status read, clears error flags |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| tx_irq | output | 1 | Transmit buffer emptied pulse |
| rx_irq | output | 1 | Frame stored pulse |
| rxd_a | input | 1 | Receive pin A |
| rxd_b | input | 1 | Receive pin B |
| txd_a | output | 1 | Transmit pin A |
| txd_b | output | 1 | Transmit pin B |
| cts | input | 1 | Far end permits sending (high) |
| rts | output | 1 | Ready to receive (high) |

## Verification
The checker watches the port-level rules on every cycle. These are the interrupt pulses and how they line up with the two streams, the stability of a held receive byte, the rule that nothing is launched while `cts` blocks, the high level on the idle transmit pin, the `rts` level against the holding stage, the precondition for an overrun, and the stickiness of the flags. The bench scenarios show what a single-cycle property cannot: the bit order and parity in the serial frames and the 2-of-3 start-bit vote against shaped noise pulses. They also cover a read that lands during the next frame, the discard on overrun and overlapping traffic in both directions.

// File: rtl/duplex_uart_pkg.sv
package duplex_uart_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // parity bit value that completes the requested parity over the data
  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/duplex_uart_rx.sv
module duplex_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] frame,
  output logic              par_err,
  output logic              frm_err
);
  import duplex_uart_pkg::*;

  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] T_A   = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] T_B   = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] T_C   = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] T_END = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST  = BIT_W'(DATA_W - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              va, vb, acc, pbit;
  logic              vote;

  // 2-of-3 vote: samples at T_A, T_B and the live level at T_C
  assign vote = (va & vb) | (va & rxd) | (vb & rxd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      va      <= 1'b1;
      vb      <= 1'b1;
      acc     <= 1'b0;
      pbit    <= 1'b0;
      done    <= 1'b0;
      frame   <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == RX_IDLE) begin
          if (!rxd) begin
            st  <= RX_START;
            cnt <= CNT_W'(1);
          end
        end else begin
          cnt <= (cnt == T_END) ? '0 : cnt + 1'b1;
          if (cnt == T_A) va <= rxd;
          if (cnt == T_B) vb <= rxd;
          if (cnt == T_C) begin
            case (st)
              RX_START: if (vote) st <= RX_IDLE;
              RX_DATA: begin
                shreg <= {vote, shreg[DATA_W-1:1]};
                acc   <= acc ^ vote;
              end
              RX_PAR:  pbit <= vote;
              RX_STOP: begin
                done    <= 1'b1;
                frame   <= shreg;
                frm_err <= !vote;
                par_err <= par_en && ((acc ^ pbit) != par_odd);
                st      <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == T_END) begin
            case (st)
              RX_START: begin
                st   <= RX_DATA;
                bitn <= '0;
                acc  <= 1'b0;
              end
              RX_DATA: begin
                if (bitn == LAST) st <= par_en ? RX_PAR : RX_STOP;
                else bitn <= bitn + 1'b1;
              end
              RX_PAR:  st <= RX_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/duplex_uart_tx.sv
module duplex_uart_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              send_ok,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              irq,
  output logic              line
);
  import duplex_uart_pkg::*;

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OSR);
  localparam int LEFT_W  = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] T_END = CNT_W'(OSR - 1);

  logic               buf_full;
  logic [DATA_W-1:0]  buf_data;
  logic               busy;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [LEFT_W-1:0]  left;

  assign in_ready = !buf_full;
  assign line     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
      busy     <= 1'b0;
      shreg    <= '1;
      cnt      <= '0;
      left     <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (in_valid && !buf_full) begin
        buf_full <= 1'b1;
        buf_data <= in_data;
      end
      if (!busy && buf_full && send_ok) begin
        buf_full <= 1'b0;
        irq      <= 1'b1;
        busy     <= 1'b1;
        cnt      <= '0;
        shreg    <= {1'b1, par_en ? parity_of(buf_data, par_odd) : 1'b1, buf_data, 1'b0};
        left     <= par_en ? LEFT_W'(DATA_W + 2) : LEFT_W'(DATA_W + 1);
      end else if (busy && tick) begin
        if (cnt == T_END) begin
          cnt <= '0;
          if (left == '0) busy <= 1'b0;
          else begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/duplex_uart.sv
module duplex_uart #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_hs_en,
  input  logic [1:0]        cfg_pin_sel,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              stat_rd,
  output logic              err_overrun,
  output logic              err_parity,
  output logic              err_frame,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              rxd_a,
  input  logic              rxd_b,
  output logic              txd_a,
  output logic              txd_b,
  input  logic              cts,
  output logic              rts
);

  logic              rx_s1, rx_s2;
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_frame;
  logic              tx_line;
  logic              hold_valid;
  logic              lost, store;

  // receive pin select and two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= cfg_pin_sel[0] ? rxd_b : rxd_a;
      rx_s2 <= rx_s1;
    end
  end

  duplex_uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .rxd     (rx_s2),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .done    (rx_done),
    .frame   (rx_frame),
    .par_err (rx_perr),
    .frm_err (rx_ferr)
  );

  duplex_uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .send_ok  (!cfg_hs_en || cts),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .irq      (tx_irq),
    .line     (tx_line)
  );

  // holding stage of the receive path
  assign lost  = rx_done && hold_valid && !rx_ready;
  assign store = rx_done && !lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid  <= 1'b0;
      rx_data     <= '0;
      rx_irq      <= 1'b0;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (hold_valid && rx_ready) hold_valid <= 1'b0;
      if (store) begin
        hold_valid <= 1'b1;
        rx_data    <= rx_frame;
        rx_irq     <= 1'b1;
      end
      err_overrun <= (err_overrun && !stat_rd) || lost;
      err_parity  <= (err_parity && !stat_rd) || (rx_done && rx_perr);
      err_frame   <= (err_frame && !stat_rd) || (rx_done && rx_ferr);
    end
  end

  assign rx_valid = hold_valid;
  assign rts      = !(cfg_hs_en && hold_valid);
  assign txd_a    = cfg_pin_sel[1] ? 1'b1 : tx_line;
  assign txd_b    = cfg_pin_sel[1] ? tx_line : 1'b1;

endmodule

// File: rtl/duplex_uart_chk.sv
module duplex_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_hs_en,
  input logic [1:0]        cfg_pin_sel,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              stat_rd,
  input logic              err_overrun,
  input logic              err_parity,
  input logic              err_frame,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              txd_a,
  input logic              txd_b,
  input logic              cts,
  input logic              rts
);

  AST_TXIRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_ready); // R2

  AST_TXIRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R2

  AST_RXIRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid); // R4

  AST_RX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R5

  AST_OVR_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_valid)); // R6

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !stat_rd) |=> err_parity); // R9

  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !stat_rd) |=> err_frame); // R9

  AST_RTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hs_en && rx_valid) |-> !rts); // R10

  AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hs_en && !cts) |=> !tx_irq); // R11

  AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pin_sel[1] ? txd_a : txd_b); // R12

endmodule

bind duplex_uart duplex_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_hs_en   (cfg_hs_en),
  .cfg_pin_sel (cfg_pin_sel),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .stat_rd     (stat_rd),
  .err_overrun (err_overrun),
  .err_parity  (err_parity),
  .err_frame   (err_frame),
  .tx_irq      (tx_irq),
  .rx_irq      (rx_irq),
  .txd_a       (txd_a),
  .txd_b       (txd_b),
  .cts         (cts),
  .rts         (rts)
);

// File: tb/duplex_uart_bench.sv
`timescale 1ns/1ps
module duplex_uart_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_hs_en = 1'b0;
  logic [1:0] cfg_pin_sel = 2'b00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_ready = 1'b0;
  logic       stat_rd = 1'b0;
  logic       rxd_a = 1'b1, rxd_b = 1'b1;
  logic       cts = 1'b1;
  logic       tx_ready, rx_valid, err_overrun, err_parity, err_frame;
  logic       tx_irq, rx_irq, txd_a, txd_b, rts;
  logic [7:0] rx_data;

  int total = 0;
  int bad   = 0;
  int n_txirq = 0;
  int n_rxirq = 0;
  bit finished = 0;
  int tick_div = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tick_div  <= (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == 3);
    if (tx_irq) n_txirq <= n_txirq + 1;
    if (rx_irq) n_rxirq <= n_rxirq + 1;
  end

  duplex_uart u_duplex_uart (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_hs_en(cfg_hs_en),
    .cfg_pin_sel(cfg_pin_sel), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stat_rd(stat_rd), .err_overrun(err_overrun), .err_parity(err_parity),
    .err_frame(err_frame), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .rxd_a(rxd_a), .rxd_b(rxd_b), .txd_a(txd_a), .txd_b(txd_b),
    .cts(cts), .rts(rts)
  );

  function automatic logic exp_par(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_rx(input logic lvl);
    if (cfg_pin_sel[0]) begin rxd_b = lvl; rxd_a = 1'($urandom % 2); end
    else begin rxd_a = lvl; rxd_b = 1'($urandom % 2); end
  endtask

  task automatic rx_quiet();
    rxd_a = 1'b1;
    rxd_b = 1'b1;
  endtask

  // start low for lo ticks, rest of the start bit high
  task automatic send_frame(input logic [7:0] d, input bit flip_par,
                            input logic stop_lvl, input int lo);
    wait_ticks(1);
    set_rx(1'b0);
    wait_ticks(lo);
    if (lo < 16) begin set_rx(1'b1); wait_ticks(16 - lo); end
    for (int i = 0; i < 8; i++) begin set_rx(d[i]); wait_ticks(16); end
    if (cfg_par_en) begin
      set_rx(exp_par(d, cfg_par_odd) ^ flip_par);
      wait_ticks(16);
    end
    set_rx(stop_lvl);
    wait_ticks(16);
    rx_quiet();
    wait_ticks(stop_lvl ? 2 : 24);
  endtask

  task automatic read_rx(output logic [7:0] d);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    d = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  function automatic logic tx_sel_pin();
    return cfg_pin_sel[1] ? txd_b : txd_a;
  endfunction

  function automatic logic tx_other_pin();
    return cfg_pin_sel[1] ? txd_a : txd_b;
  endfunction

  task automatic cap_tx(output logic [7:0] d, output bit par_ok,
                        output bit stop_ok, output bit other_ok);
    other_ok = 1;
    @(negedge clk);
    while (tx_sel_pin() != 1'b0) begin
      if (tx_other_pin() != 1'b1) other_ok = 0;
      @(negedge clk);
    end
    wait_ticks(8);
    for (int i = 0; i < 8; i++) begin
      wait_ticks(16);
      d[i] = tx_sel_pin();
      if (tx_other_pin() != 1'b1) other_ok = 0;
    end
    par_ok = 1;
    if (cfg_par_en) begin
      wait_ticks(16);
      par_ok = (tx_sel_pin() == exp_par(d, cfg_par_odd));
    end
    wait_ticks(16);
    stop_ok = (tx_sel_pin() == 1'b1);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, got;
    bit pok, sok, ook;
    int irq0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(tx_ready && !rx_valid && txd_a && txd_b && rts, "R2 reset idle",
          {tx_ready, rx_valid, txd_a, txd_b, rts}, 5'b10111);
    check(!err_overrun && !err_parity && !err_frame, "R9 reset flags",
          {err_overrun, err_parity, err_frame}, 0);

    // R1 R12: random transmit frames, mixed parity and pin
    for (int k = 0; k < 6; k++) begin
      cfg_par_en  = 1'($urandom % 2);
      cfg_par_odd = 1'($urandom % 2);
      cfg_pin_sel = 2'($urandom % 4);
      d = 8'($urandom);
      irq0 = n_txirq;
      fork
        tx_write(d);
        cap_tx(got, pok, sok, ook);
      join
      check(got == d, "R1 tx data", got, d);
      check(pok && sok, "R1 tx parity/stop", {pok, sok}, 2'b11);
      check(ook, "R12 idle tx pin high", ook, 1);
      check(n_txirq == irq0 + 1, "R2 tx_irq count", n_txirq - irq0, 1);
    end

    // R2: second byte buffered while first shifts
    cfg_par_en = 1'b0; cfg_pin_sel = 2'b00;
    d = 8'hA5; d2 = 8'h3C; irq0 = n_txirq;
    fork
      begin tx_write(d); tx_write(d2); end
      begin
        cap_tx(got, pok, sok, ook);
        check(got == d, "R2 first byte", got, d);
        cap_tx(got, pok, sok, ook);
        check(got == d2, "R2 buffered byte", got, d2);
      end
    join
    check(n_txirq == irq0 + 2, "R2 two tx_irq", n_txirq - irq0, 2);

    // R4 R12: random receive frames with noise on the other pin
    for (int k = 0; k < 6; k++) begin
      cfg_par_en  = 1'($urandom % 2);
      cfg_par_odd = 1'($urandom % 2);
      cfg_pin_sel = 2'($urandom % 4);
      d = 8'($urandom);
      irq0 = n_rxirq;
      send_frame(d, 0, 1'b1, 16);
      check(rx_valid && rx_data == d, "R4 rx byte", rx_data, d);
      check(n_rxirq == irq0 + 1, "R4 rx_irq count", n_rxirq - irq0, 1);
      check(!err_parity && !err_frame, "R12 other pin ignored",
            {err_parity, err_frame}, 0);
      read_rx(got);
    end

    // R3: start-bit vote
    cfg_par_en = 1'b0; cfg_pin_sel = 2'b00; irq0 = n_rxirq;
    wait_ticks(1); rxd_a = 1'b0; wait_ticks(3); rxd_a = 1'b1; wait_ticks(200);
    check(!rx_valid && n_rxirq == irq0, "R3 short pulse rejected", rx_valid, 0);
    wait_ticks(1); rxd_a = 1'b0; wait_ticks(8); rxd_a = 1'b1; wait_ticks(200);
    check(!rx_valid && n_rxirq == irq0, "R3 one-of-three rejected", rx_valid, 0);
    send_frame(8'h96, 0, 1'b1, 9);
    check(rx_valid && rx_data == 8'h96, "R3 two-of-three accepted", rx_data, 8'h96);
    read_rx(got);

    // R5: read lands while the next frame shifts in
    send_frame(8'h11, 0, 1'b1, 16);
    fork
      send_frame(8'h22, 0, 1'b1, 16);
      begin
        wait_ticks(60);
        read_rx(got);
        check(got == 8'h11, "R5 first held byte", got, 8'h11);
      end
    join
    check(rx_valid && rx_data == 8'h22 && !err_overrun, "R5 second byte stored",
          rx_data, 8'h22);
    read_rx(got);

    // R6: overrun keeps held byte
    send_frame(8'h5A, 0, 1'b1, 16);
    irq0 = n_rxirq;
    send_frame(8'hC3, 0, 1'b1, 16);
    check(err_overrun, "R6 overrun flag", err_overrun, 1);
    check(rx_data == 8'h5A && n_rxirq == irq0, "R6 held byte kept", rx_data, 8'h5A);
    read_rx(got);
    check(!rx_valid, "R6 discarded frame absent", rx_valid, 0);

    // R7 R9: parity error, sticky then cleared
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send_frame(8'h71, 1, 1'b1, 16);
    check(err_parity && rx_data == 8'h71, "R7 parity error", err_parity, 1);
    read_rx(got);
    send_frame(8'h0F, 0, 1'b1, 16);
    check(err_parity && err_overrun, "R9 flags sticky", {err_overrun, err_parity}, 2'b11);
    read_rx(got);
    clear_flags();
    check(!err_overrun && !err_parity && !err_frame, "R9 status read clears",
          {err_overrun, err_parity, err_frame}, 0);

    // R8: framing error
    cfg_par_en = 1'b0;
    send_frame(8'hE7, 0, 1'b0, 16);
    check(err_frame, "R8 framing error", err_frame, 1);
    read_rx(got);
    clear_flags();

    // R10: RTS with handshake
    cfg_hs_en = 1'b1;
    @(negedge clk);
    check(rts, "R10 rts idle high", rts, 1);
    send_frame(8'h42, 0, 1'b1, 16);
    check(!rts, "R10 rts low while held", rts, 0);
    read_rx(got);
    check(rts, "R10 rts back after read", rts, 1);

    // R11: CTS holds transmission
    cts = 1'b0; irq0 = n_txirq;
    tx_write(8'h9D);
    repeat (300) @(negedge clk);
    check(!tx_ready && txd_a && n_txirq == irq0, "R11 cts blocks",
          {tx_ready, txd_a}, 2'b01);
    fork
      begin repeat (3) @(negedge clk); cts = 1'b1; end
      cap_tx(got, pok, sok, ook);
    join
    check(got == 8'h9D, "R11 sent after cts", got, 8'h9D);
    cfg_hs_en = 1'b0;

    // R13: both directions at once
    cfg_pin_sel = 2'b11; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    d = 8'($urandom); d2 = 8'($urandom);
    fork
      begin tx_write(d); cap_tx(got, pok, sok, ook); end
      send_frame(d2, 0, 1'b1, 16);
    join
    check(got == d && pok && sok, "R13 tx during rx", got, d);
    check(rx_valid && rx_data == d2 && !err_parity, "R13 rx during tx", rx_data, d2);
    read_rx(got);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule